// File: doc/BRIEF.md
# Serial Delay Configuration Port

This block receives delay settings over three wires (serial data, serial clock and load strobe) and holds them for two programmable delay channels and a shared mode flag. Bits are shifted into an 11-bit word on rising serial-clock edges. The word holds a 9-bit delay value, a channel-select bit and a mode bit.

While the load strobe is high, the holding registers are transparent. The channel-select bit steers the delay value into the channel 0 or the channel 1 register. The mode register follows the word no matter which channel is selected. When the strobe goes low, all three registers hold their values.

The three serial inputs are asynchronous to the system clock. Each one passes through a two-flop synchronizer. Serial-clock rising edges are then detected in the system-clock domain. Every output is a register in the system-clock domain.

Top module: `dcfg_top`

## Requirements
- R1: The word is 11 bits and is sent most significant bit first. After 11 shifts, the first bit sent sits at bit 10 (mode). The second bit sits at bit 9 (channel select). The remaining bits fill bits 8 down to 0 (delay D8 down to D0).
- R2: A bit is shifted in only on a rising edge of the serial clock. A falling edge, or a serial clock held at a steady level, moves no bit.
- R3: While the load strobe is high, the selected channel register follows bits 8..0 of the word. This includes bits shifted in while the strobe stays high.
- R4: While the load strobe is low, both channel registers and the mode register keep their values, whatever is shifted in.
- R5: Channel select 0 writes the channel 0 register and leaves the channel 1 register unchanged. Channel select 1 writes the channel 1 register and leaves the channel 0 register unchanged.
- R6: The mode register takes bit 10 of the word on every load, for either channel select. A value of 1 means cascaded (extended) delay mode.
- R7: Reset clears both channel registers and the mode register to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_din | input | 1 | Serial data, asynchronous |
| ser_clk | input | 1 | Serial clock, asynchronous; data is taken on its rising edge |
| ser_load | input | 1 | Load strobe, asynchronous; registers are transparent while it is high |
| dly_ch0 | output | 9 | Delay setting for channel 0 |
| dly_ch1 | output | 9 | Delay setting for channel 1 |
| cascade_mode | output | 1 | 1 selects cascaded delay mode |

## Verification
A serial-clock edge and the transparent copy into the holding registers can fall in the same system cycle. This happens when the strobe is held high while another bit is shifted in. The new bit can also move a different value into the channel-select position, so the copy then targets the other channel. The bench keeps the strobe high, shifts one more bit, and compares both channel registers and the mode register against its own model of the shifted word. It then drops the strobe and shifts a whole word, to confirm that nothing moves once the strobe is low.

// File: rtl/dcfg_pkg.sv
`timescale 1ns/1ps
package dcfg_pkg;
  localparam int DLY_W  = 9;
  localparam int WORD_W = DLY_W + 2;
  localparam int CH_N   = 2;
  localparam int SEL_W  = $clog2(CH_N);

  typedef logic [WORD_W-1:0] cfg_word_t;
  typedef logic [DLY_W-1:0]  dly_t;

  // Delay field: low DLY_W bits of the word
  function automatic dly_t word_delay(cfg_word_t w);
    return w[DLY_W-1:0];
  endfunction

  // Channel select: the bit just above the delay field
  function automatic logic [SEL_W-1:0] word_chsel(cfg_word_t w);
    return w[DLY_W +: SEL_W];
  endfunction

  // Mode flag: most significant bit
  function automatic logic word_mode(cfg_word_t w);
    return w[WORD_W-1];
  endfunction

  // MSB-first serial step
  function automatic cfg_word_t word_shift(cfg_word_t w, logic b);
    return {w[WORD_W-2:0], b};
  endfunction
endpackage

// File: rtl/dcfg_sync.sv
`timescale 1ns/1ps
module dcfg_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= async_in;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/dcfg_shifter.sv
`timescale 1ns/1ps
module dcfg_shifter
  import dcfg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sclk_s,
  input  logic      din_s,
  output logic      shift_evt,
  output cfg_word_t word_q
);
  logic sclk_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_prev_q <= 1'b0;
    else        sclk_prev_q <= sclk_s;
  end

  // Rising edge of the synchronized serial clock
  assign shift_evt = sclk_s & ~sclk_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         word_q <= '0;
    else if (shift_evt) word_q <= word_shift(word_q, din_s);
  end
endmodule

// File: rtl/dcfg_latch_bank.sv
`timescale 1ns/1ps
module dcfg_latch_bank
  import dcfg_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load_open,
  input  cfg_word_t                  word,
  output logic [CH_N-1:0][DLY_W-1:0] dly_q,
  output logic                       mode_q
);
  logic [CH_N-1:0] ch_wr;

  for (genvar c = 0; c < CH_N; c++) begin : g_ch
    assign ch_wr[c] = load_open && (word_chsel(word) == SEL_W'(c));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        dly_q[c] <= '0;
      else if (ch_wr[c]) dly_q[c] <= word_delay(word);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mode_q <= 1'b0;
    else if (load_open) mode_q <= word_mode(word);
  end
endmodule

// File: rtl/dcfg_top.sv
`timescale 1ns/1ps
module dcfg_top
  import dcfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_din,
  input  logic             ser_clk,
  input  logic             ser_load,
  output logic [DLY_W-1:0] dly_ch0,
  output logic [DLY_W-1:0] dly_ch1,
  output logic             cascade_mode
);
  logic [2:0]                 sync_bus;
  logic                       din_s;
  logic                       sclk_s;
  logic                       load_open;
  logic                       shift_evt;
  cfg_word_t                  word;
  logic [CH_N-1:0][DLY_W-1:0] dly_q;

  dcfg_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({ser_load, ser_clk, ser_din}),
    .sync_out (sync_bus)
  );

  assign din_s     = sync_bus[0];
  assign sclk_s    = sync_bus[1];
  assign load_open = sync_bus[2];

  dcfg_shifter u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_s    (sclk_s),
    .din_s     (din_s),
    .shift_evt (shift_evt),
    .word_q    (word)
  );

  dcfg_latch_bank u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_open (load_open),
    .word      (word),
    .dly_q     (dly_q),
    .mode_q    (cascade_mode)
  );

  assign dly_ch0 = dly_q[0];
  assign dly_ch1 = dly_q[1];
endmodule

// File: rtl/dcfg_chk.sv
`timescale 1ns/1ps
module dcfg_chk
  import dcfg_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             shift_evt,
  input logic             din_s,
  input cfg_word_t        word,
  input logic             load_open,
  input logic [DLY_W-1:0] dly_ch0,
  input logic [DLY_W-1:0] dly_ch1,
  input logic             cascade_mode
);
  // R1: MSB-first shift on each detected edge
  a_r1_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
    shift_evt |=> (word[WORD_W-1:1] == $past(word[WORD_W-2:0])) && (word[0] == $past(din_s)));

  // R2: without an edge the word does not move
  a_r2_no_edge_no_shift: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_evt |=> $stable(word));

  // R3: transparent copy into the selected channel
  a_r3_follow_ch0: assert property (@(posedge clk) disable iff (!rst_n)
    (load_open && word[DLY_W] == 1'b0) |=> dly_ch0 == $past(word[DLY_W-1:0]));
  a_r3_follow_ch1: assert property (@(posedge clk) disable iff (!rst_n)
    (load_open && word[DLY_W] == 1'b1) |=> dly_ch1 == $past(word[DLY_W-1:0]));

  // R4: strobe low holds everything
  a_r4_hold_closed: assert property (@(posedge clk) disable iff (!rst_n)
    !load_open |=> $stable(dly_ch0) && $stable(dly_ch1) && $stable(cascade_mode));

  // R5: the unselected channel keeps its value
  a_r5_unsel_ch1: assert property (@(posedge clk) disable iff (!rst_n)
    (load_open && word[DLY_W] == 1'b0) |=> $stable(dly_ch1));
  a_r5_unsel_ch0: assert property (@(posedge clk) disable iff (!rst_n)
    (load_open && word[DLY_W] == 1'b1) |=> $stable(dly_ch0));

  // R6: mode follows bit 10 on any load
  a_r6_mode_any_ch: assert property (@(posedge clk) disable iff (!rst_n)
    load_open |=> cascade_mode == $past(word[WORD_W-1]));
endmodule

bind dcfg_top dcfg_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .shift_evt    (shift_evt),
  .din_s        (din_s),
  .word         (word),
  .load_open    (load_open),
  .dly_ch0      (dly_ch0),
  .dly_ch1      (dly_ch1),
  .cascade_mode (cascade_mode)
);

// File: tb/dcfg_top_bench.sv
`timescale 1ns/1ps
module dcfg_top_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ser_din = 1'b0;
  logic       ser_clk = 1'b0;
  logic       ser_load = 1'b0;
  logic [8:0] dly_ch0;
  logic [8:0] dly_ch1;
  logic       cascade_mode;

  always #2.5 clk = ~clk;

  dcfg_top u_dcfg_top (
    .clk          (clk),
    .rst_n        (rst_n),
    .ser_din      (ser_din),
    .ser_clk      (ser_clk),
    .ser_load     (ser_load),
    .dly_ch0      (dly_ch0),
    .dly_ch1      (dly_ch1),
    .cascade_mode (cascade_mode)
  );

  // Word layout: [10]=mode, [9]=channel select, [8:0]=delay
  localparam int NV = 6;
  localparam logic [10:0] VEC [NV] = '{
    11'h0AB, 11'h3FF, 11'h401, 11'h7FE, 11'h155, 11'h2AA
  };

  int   n_chk = 0;
  int   n_bad = 0;
  bit   summary_done = 0;
  int   m_sh = 0;
  int   m_c0 = 0;
  int   m_c1 = 0;
  int   m_md = 0;

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  // Bench model of a transparent update from the shifted word
  task automatic model_load();
    if (((m_sh >> 9) & 1) == 1) m_c1 = m_sh % 512;
    else                        m_c0 = m_sh % 512;
    m_md = (m_sh >> 10) & 1;
  endtask

  task automatic send_bit(bit b, bit transparent);
    ser_din = b;
    wait_clk(4);
    ser_clk = 1'b1;
    wait_clk(4);
    ser_clk = 1'b0;
    m_sh = ((m_sh * 2) + int'(b)) % 2048;
    if (transparent) model_load();
  endtask

  task automatic send_word(logic [10:0] w);
    for (int i = 10; i >= 0; i--) send_bit(w[i], 1'b0);
  endtask

  task automatic pulse_load();
    ser_load = 1'b1;
    wait_clk(6);
    ser_load = 1'b0;
    wait_clk(6);
    model_load();
  endtask

  task automatic check_all(string req);
    check(req, int'(dly_ch0), m_c0);
    check(req, int'(dly_ch1), m_c1);
    check(req, int'(cascade_mode), m_md);
  endtask

  initial begin
    wait_clk(3);
    // R7: reset state while reset is held
    check("R7 reset ch0", int'(dly_ch0), 0);
    check("R7 reset ch1", int'(dly_ch1), 0);
    check("R7 reset mode", int'(cascade_mode), 0);
    rst_n = 1'b1;
    wait_clk(3);

    // R1 R5 R6: table walk, each word loaded then checked
    for (int v = 0; v < NV; v++) begin
      send_word(VEC[v]);
      pulse_load();
      check_all("R1/R5/R6 vector");
    end

    // R4 R2: strobe low, a full word shifted: nothing moves
    send_word(11'h5A5);
    wait_clk(6);
    check_all("R4 hold while strobe low");
    // R2: falling-only activity, data toggled with serial clock idle
    for (int i = 0; i < 4; i++) begin
      ser_din = ~ser_din;
      wait_clk(3);
    end
    ser_load = 1'b1;
    wait_clk(6);
    ser_load = 1'b0;
    wait_clk(6);
    model_load();
    check_all("R2 data toggle without edge moves no bit");

    // R3: strobe held high while one more bit arrives
    send_word(11'h0F0);
    ser_load = 1'b1;
    wait_clk(6);
    model_load();
    check_all("R3 transparent initial");
    send_bit(1'b1, 1'b1);   // shifted word now 0x1E1: ch0 follows
    wait_clk(6);
    check_all("R3 follows new bit");
    send_bit(1'b0, 1'b1);   // 0x3C2: select flips to ch1
    wait_clk(6);
    check_all("R3 select moves during strobe");
    ser_load = 1'b0;
    wait_clk(6);
    send_word(11'h7FF);
    wait_clk(6);
    check_all("R4 hold after strobe falls");

    // R7: reset again clears loaded state
    rst_n = 1'b0;
    wait_clk(2);
    m_c0 = 0; m_c1 = 0; m_md = 0;
    check_all("R7 second reset");
    rst_n = 1'b1;
    wait_clk(2);

    if (!summary_done) begin
      summary_done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    end
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!summary_done) begin
      summary_done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule